// File: doc/BRIEF.md
# Overhead Byte Capture and Routing

This block takes the two per-frame overhead bytes of a received E3 stream, the network-requirement byte and the general-communication byte, and handles each one on its own path. Each byte has to show the same value in several consecutive frames before it is accepted. Only then is it copied into a status register, and a sticky flag is raised if the accepted value differs from the one already held. The upstream frame aligner supplies a frame-boundary pulse and one strobe per byte, with the byte on a parallel bus. Bit 7 of that bus is the first bit received on the line, which is bit 1 of the overhead byte.

The status registers use register order, not line order. The first bit received (the MSB) is stored in bit 0 and the last bit received (the LSB) is stored in bit 7.

A second path sends the raw byte, in line order and with a byte strobe, to a downstream serial HDLC receiver. A select input decides which of the two overhead bytes takes that path. The select is sampled only at frame boundaries, so the forwarded stream never switches source partway through a frame.

Top module: `ovh_capture_top`

## Requirements
- R1: After reset, both status registers read 0x00, both change flags are 0 and the forwarded strobe is 0.
- R2: A byte value is accepted into its status register only on the PERSIST-th consecutive strobe carrying that same value (PERSIST defaults to 3). A different value in between restarts the count, and until acceptance the register keeps its previous contents. The register updates at the clock edge that samples the accepting strobe.
- R3: The status register holds the accepted byte bit-reversed relative to the input bus. Register bit 0 equals input bit 7 (the first bit received), and register bit 7 equals input bit 0.
- R4: A change flag sets at the edge where its byte is accepted with a value different from the register's current contents. Accepting the value already held leaves the flag unchanged.
- R5: A change flag stays set until its one-cycle clear input is pulsed. It reads 0 from the next cycle on, unless a new change is accepted in the same cycle as the clear, in which case the flag stays 1.
- R6: When the forward select is 0 the network-requirement byte is forwarded, and when it is 1 the general-communication byte is forwarded. One cycle after a strobe of the selected byte, the forward strobe is 1 for one cycle and the forward byte equals the input byte unchanged (line order). Strobes of the unselected byte produce no forward strobe.
- R7: The forward select takes effect only at a frame-boundary pulse. A change of the select input between pulses does not change which byte is forwarded until the next pulse.
- R8: The two bytes are independent. Strobes of one byte never change the other byte's status register or change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | One-cycle frame-boundary pulse |
| fwd_sel | input | 1 | Forward source: 0 network-requirement byte, 1 general-communication byte |
| nr_stb | input | 1 | Network-requirement byte valid |
| nr_byte | input | BYTE_W | Network-requirement byte, bit 7 first on the line |
| gc_stb | input | 1 | General-communication byte valid |
| gc_byte | input | BYTE_W | General-communication byte, bit 7 first on the line |
| nr_chg_clr | input | 1 | Clears the network-requirement change flag |
| gc_chg_clr | input | 1 | Clears the general-communication change flag |
| nr_reg | output | BYTE_W | Accepted network-requirement byte, register order |
| nr_chg | output | 1 | Sticky network-requirement change flag |
| gc_reg | output | BYTE_W | Accepted general-communication byte, register order |
| gc_chg | output | 1 | Sticky general-communication change flag |
| dl_stb | output | 1 | Forwarded byte strobe |
| dl_byte | output | BYTE_W | Forwarded raw byte, line order |

## Verification
- **Interrupted run.** The bench sends a value twice, then a different value, then the first value again. A counter that fails to restart on the mismatch would latch too early.
- **Bit order.** It uses byte values that are not palindromes. A design that stores the byte unreversed, or forwards it reversed, therefore produces a visibly wrong value.
- **Flag behaviour.** It re-accepts the value already held, which a design that flags every acceptance would wrongly mark as a change. It also pulses the clear in the same cycle as a real change, where a design that gives clear priority would lose the event.
- **Select timing.** It moves the select input in the middle of a frame. A design that reads the select directly would redirect the forwarded stream before the frame boundary.

// File: rtl/ovh_pkg.sv
package ovh_pkg;

   // Source codes for the forwarding path and the per-source arrays
   typedef enum logic {
      SRC_NR = 1'b0,
      SRC_GC = 1'b1
   } ovh_src_e;

   localparam int NUM_SRC = 2;

endpackage

// File: rtl/ovh_persist.sv
// Persistence integrator for one overhead byte: a value must repeat on
// PERSIST consecutive strobes before it replaces the held value.
module ovh_persist #(
   parameter int W       = 8,
   parameter int PERSIST = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic [W-1:0] din,
   input  logic         chg_clr,
   output logic [W-1:0] held,
   output logic         chg
);

   localparam int              CNT_W   = (PERSIST < 2) ? 1 : $clog2(PERSIST + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PERSIST);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (PERSIST < 1) begin : g_bad_persist
         $error("ovh_persist: PERSIST must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("ovh_persist: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]     cand;
   logic [CNT_W-1:0] run_len;
   logic [CNT_W-1:0] run_nxt;
   logic             accept;
   logic             differs;

   always_comb begin
      if (din == cand) begin
         run_nxt = (run_len == CNT_TOP) ? run_len : run_len + CNT_ONE;
      end else begin
         run_nxt = CNT_ONE;
      end
      accept  = stb && (run_nxt == CNT_TOP);
      differs = (din != held);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand    <= '0;
         run_len <= '0;
      end else if (stb) begin
         cand    <= din;
         run_len <= run_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else if (accept && differs) begin
         held <= din;
      end
   end

   // Set has priority over clear so no change event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg <= 1'b0;
      end else if (accept && differs) begin
         chg <= 1'b1;
      end else if (chg_clr) begin
         chg <= 1'b0;
      end
   end

endmodule

// File: rtl/ovh_route.sv
// Source selector for the HDLC path; select is taken only at frame start.
module ovh_route
   import ovh_pkg::*;
#(
   parameter int W       = 8,
   parameter bit FWD_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frm_start,
   input  logic         sel_in,
   input  logic         nr_stb,
   input  logic [W-1:0] nr_byte,
   input  logic         gc_stb,
   input  logic [W-1:0] gc_byte,
   output logic         sel_q,
   output logic         out_stb,
   output logic [W-1:0] out_byte
);

   ovh_src_e     src_q;
   logic         pick_stb;
   logic [W-1:0] pick_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_NR;
      end else if (frm_start) begin
         src_q <= ovh_src_e'(sel_in);
      end
   end

   assign sel_q = (src_q == SRC_GC);

   always_comb begin
      unique case (src_q)
         SRC_GC: begin
            pick_stb  = gc_stb;
            pick_byte = gc_byte;
         end
         default: begin
            pick_stb  = nr_stb;
            pick_byte = nr_byte;
         end
      endcase
   end

   generate
      if (FWD_REG) begin : g_fwd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_stb  <= 1'b0;
               out_byte <= '0;
            end else begin
               out_stb <= pick_stb;
               if (pick_stb) begin
                  out_byte <= pick_byte;
               end
            end
         end
      end else begin : g_fwd_comb
         assign out_stb  = pick_stb;
         assign out_byte = pick_byte;
      end
   endgenerate

endmodule

// File: rtl/ovh_capture_top.sv
module ovh_capture_top
   import ovh_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int PERSIST = 3,
   parameter bit FWD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic              fwd_sel,
   input  logic              nr_stb,
   input  logic [BYTE_W-1:0] nr_byte,
   input  logic              gc_stb,
   input  logic [BYTE_W-1:0] gc_byte,
   input  logic              nr_chg_clr,
   input  logic              gc_chg_clr,
   output logic [BYTE_W-1:0] nr_reg,
   output logic              nr_chg,
   output logic [BYTE_W-1:0] gc_reg,
   output logic              gc_chg,
   output logic              dl_stb,
   output logic [BYTE_W-1:0] dl_byte
);

   localparam int MSB = BYTE_W - 1;

   generate
      if (BYTE_W < 1) begin : g_bad_width
         $error("ovh_capture_top: BYTE_W must be at least 1");
      end
   endgenerate

   logic              stb_a  [NUM_SRC];
   logic [BYTE_W-1:0] din_a  [NUM_SRC];
   logic              clr_a  [NUM_SRC];
   logic [BYTE_W-1:0] held_a [NUM_SRC];
   logic              chg_a  [NUM_SRC];
   logic [BYTE_W-1:0] regv_a [NUM_SRC];
   logic              route_sel;

   assign stb_a[SRC_NR] = nr_stb;
   assign din_a[SRC_NR] = nr_byte;
   assign clr_a[SRC_NR] = nr_chg_clr;
   assign stb_a[SRC_GC] = gc_stb;
   assign din_a[SRC_GC] = gc_byte;
   assign clr_a[SRC_GC] = gc_chg_clr;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         ovh_persist #(
            .W       (BYTE_W),
            .PERSIST (PERSIST)
         ) u_persist (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (stb_a[s]),
            .din     (din_a[s]),
            .chg_clr (clr_a[s]),
            .held    (held_a[s]),
            .chg     (chg_a[s])
         );
         // Line order to register order: first received bit lands in bit 0
         for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
            assign regv_a[s][b] = held_a[s][MSB-b];
         end
      end
   endgenerate

   assign nr_reg = regv_a[SRC_NR];
   assign nr_chg = chg_a[SRC_NR];
   assign gc_reg = regv_a[SRC_GC];
   assign gc_chg = chg_a[SRC_GC];

   ovh_route #(
      .W       (BYTE_W),
      .FWD_REG (FWD_REG)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .sel_in    (fwd_sel),
      .nr_stb    (nr_stb),
      .nr_byte   (nr_byte),
      .gc_stb    (gc_stb),
      .gc_byte   (gc_byte),
      .sel_q     (route_sel),
      .out_stb   (dl_stb),
      .out_byte  (dl_byte)
   );

endmodule

// File: rtl/ovh_capture_chk.sv
module ovh_capture_chk #(
   parameter int BYTE_W  = 8,
   parameter bit FWD_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_start,
   input logic              nr_stb,
   input logic              gc_stb,
   input logic              nr_chg_clr,
   input logic              gc_chg_clr,
   input logic [BYTE_W-1:0] nr_reg,
   input logic              nr_chg,
   input logic [BYTE_W-1:0] gc_reg,
   input logic              gc_chg,
   input logic              dl_stb,
   input logic              route_sel
);

   assert_nr_needs_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nr_reg) |-> $past(nr_stb));

   assert_gc_only_own_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gc_reg) |-> $past(gc_stb));

   assert_nr_update_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nr_reg) |-> nr_chg);

   assert_gc_update_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gc_reg) |-> gc_chg);

   assert_nr_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (nr_chg && !nr_chg_clr) |=> nr_chg);

   assert_gc_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_chg && !gc_chg_clr) |=> gc_chg);

   assert_sel_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(route_sel) |-> $past(frm_start));

   generate
      if (FWD_REG) begin : g_fwd_chk
         assert_fwd_follows_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dl_stb |-> $past(route_sel ? gc_stb : nr_stb));
      end
   endgenerate

endmodule

bind ovh_capture_top ovh_capture_chk #(
   .BYTE_W  (BYTE_W),
   .FWD_REG (FWD_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_start  (frm_start),
   .nr_stb     (nr_stb),
   .gc_stb     (gc_stb),
   .nr_chg_clr (nr_chg_clr),
   .gc_chg_clr (gc_chg_clr),
   .nr_reg     (nr_reg),
   .nr_chg     (nr_chg),
   .gc_reg     (gc_reg),
   .gc_chg     (gc_chg),
   .dl_stb     (dl_stb),
   .route_sel  (route_sel)
);

// File: tb/sim_ovh_capture_top.sv
`timescale 1ns/1ps
module sim_ovh_capture_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_start = 1'b0;
   logic       fwd_sel = 1'b0;
   logic       nr_stb = 1'b0;
   logic [7:0] nr_byte = 8'h00;
   logic       gc_stb = 1'b0;
   logic [7:0] gc_byte = 8'h00;
   logic       nr_chg_clr = 1'b0;
   logic       gc_chg_clr = 1'b0;
   logic [7:0] nr_reg, gc_reg, dl_byte;
   logic       nr_chg, gc_chg, dl_stb;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   ovh_capture_top u0 (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .fwd_sel(fwd_sel),
      .nr_stb(nr_stb), .nr_byte(nr_byte), .gc_stb(gc_stb), .gc_byte(gc_byte),
      .nr_chg_clr(nr_chg_clr), .gc_chg_clr(gc_chg_clr),
      .nr_reg(nr_reg), .nr_chg(nr_chg), .gc_reg(gc_reg), .gc_chg(gc_chg),
      .dl_stb(dl_stb), .dl_byte(dl_byte)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One strobe cycle; returns at the negedge after the sampling posedge
   task automatic send_nr(input logic [7:0] v, input logic clr = 1'b0);
      @(negedge clk);
      nr_stb = 1'b1; nr_byte = v; nr_chg_clr = clr;
      @(negedge clk);
      nr_stb = 1'b0; nr_chg_clr = 1'b0;
   endtask

   task automatic send_gc(input logic [7:0] v);
      @(negedge clk);
      gc_stb = 1'b1; gc_byte = v;
      @(negedge clk);
      gc_stb = 1'b0;
   endtask

   task automatic frame_pulse();
      @(negedge clk);
      frm_start = 1'b1;
      @(negedge clk);
      frm_start = 1'b0;
   endtask

   task automatic clear_nr();
      @(negedge clk);
      nr_chg_clr = 1'b1;
      @(negedge clk);
      nr_chg_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 nr_reg", nr_reg, 8'h00);
      check("R1 gc_reg", gc_reg, 8'h00);
      check("R1 nr_chg", {7'd0, nr_chg}, 8'h00);
      check("R1 gc_chg", {7'd0, gc_chg}, 8'h00);
      check("R1 dl_stb", {7'd0, dl_stb}, 8'h00);
   endtask

   task automatic t_persist();
      send_nr(8'hC1);
      send_nr(8'hC1);
      check("R2 not yet after two", nr_reg, 8'h00);
      check("R4 no flag before accept", {7'd0, nr_chg}, 8'h00);
      send_nr(8'hC1);
      check("R3 reversed after three", nr_reg, 8'h83);
      check("R4 flag on change", {7'd0, nr_chg}, 8'h01);
   endtask

   task automatic t_restart();
      clear_nr();
      send_nr(8'h12);
      send_nr(8'h12);
      send_nr(8'h55);
      send_nr(8'h12);
      send_nr(8'h12);
      check("R2 restart after mismatch", nr_reg, 8'h83);
      check("R2 no flag on interrupted run", {7'd0, nr_chg}, 8'h00);
      send_nr(8'h12);
      check("R3 accepted 0x12", nr_reg, 8'h48);
   endtask

   task automatic t_sticky();
      repeat (3) @(negedge clk);
      check("R5 flag holds", {7'd0, nr_chg}, 8'h01);
      clear_nr();
      check("R5 flag cleared", {7'd0, nr_chg}, 8'h00);
      send_nr(8'h12);
      send_nr(8'h12);
      send_nr(8'h12);
      check("R4 same value no flag", {7'd0, nr_chg}, 8'h00);
      check("R4 same value reg", nr_reg, 8'h48);
      send_nr(8'h40);
      send_nr(8'h40);
      send_nr(8'h40, 1'b1);
      check("R5 set wins over clear", {7'd0, nr_chg}, 8'h01);
      check("R3 accepted 0x40", nr_reg, 8'h02);
   endtask

   task automatic t_indep();
      send_gc(8'hF0);
      send_gc(8'hF0);
      send_gc(8'hF0);
      check("R8 gc reg", gc_reg, 8'h0F);
      check("R8 gc flag", {7'd0, gc_chg}, 8'h01);
      check("R8 nr reg untouched", nr_reg, 8'h02);
   endtask

   task automatic t_route();
      fwd_sel = 1'b0;
      frame_pulse();
      send_gc(8'h33);
      check("R6 unselected no strobe", {7'd0, dl_stb}, 8'h00);
      send_nr(8'h9E);
      check("R6 fwd strobe nr", {7'd0, dl_stb}, 8'h01);
      check("R6 fwd byte nr", dl_byte, 8'h9E);
      @(negedge clk);
      check("R6 strobe one cycle", {7'd0, dl_stb}, 8'h00);
   endtask

   task automatic t_select();
      fwd_sel = 1'b1;
      send_gc(8'h77);
      check("R7 mid-frame select ignored gc", {7'd0, dl_stb}, 8'h00);
      send_nr(8'h5A);
      check("R7 still nr mid-frame", dl_byte, 8'h5A);
      frame_pulse();
      send_nr(8'hA1);
      check("R7 nr dropped after boundary", {7'd0, dl_stb}, 8'h00);
      send_gc(8'h77);
      check("R6 fwd strobe gc", {7'd0, dl_stb}, 8'h01);
      check("R6 fwd byte gc line order", dl_byte, 8'h77);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_persist();
      t_restart();
      t_sticky();
      t_indep();
      t_route();
      t_select();
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule